// File: doc/BRIEF.md
# Parallel SAR Converter Sequencer

This block runs a 12-bit successive-approximation converter that sits on a parallel, bidirectional data bus. Once reset is released it loops without a break. It pulses the active-low conversion-start line, waits for the conversion to finish, and then reads the result with chip select and read held low together. Each sample goes out on a 16-bit result word with a flag that says a valid sample is present. The converter's master clock comes in on a separate input and is forwarded to the converter unchanged. A copy of that clock, synchronised into the system clock domain, is used to time the conversion.

A host writes the converter's internal registers through a low-active request and a ready flag. The sequencer acknowledges a request by dropping ready. A request that arrives during a conversion is held back until that conversion is over. Once a write is owed, no new conversion starts. The write itself drives the bus for a short window around the write strobe and releases it afterwards. The sequencer then returns to converting.

Top module: `sar_pbus_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, chip select, read, write and conversion-start are all high, write-ready is 1, read-ready is 0 and the result word is zero.
- R2: Every conversion starts with conversion-start held low for exactly STROBE_CYC clocks, with no bus strobe active. The result is not read until the busy input is low and at least CONV_CLKS rising edges of the converter clock have passed since conversion-start fell.
- R3: A read holds chip select and read low together for exactly STROBE_CYC clocks. The sample on the bus goes into result bits [11:0], and bits [15:12] (the channel tag) are zero because transfers are 12-bit words. The result word changes only at the end of a read.
- R4: Read-ready stays 0 until the first result has been captured and stays 1 from then on.
- R5: At least GAP_CYC clocks with every strobe high separate the end of a read from the next fall of conversion-start.
- R6: When no conversion is in flight, write-ready goes low one clock after the write request is sampled low.
- R7: A write request that arrives while a conversion is in flight leaves write-ready high until that conversion has finished.
- R8: A register write holds chip select and write low together for exactly STROBE_CYC clocks. The bus carries the host's 12-bit data, and the word/byte select output is high at all times.
- R9: The sequencer drives the bus only from one clock before write falls to one clock after it rises. It never drives the bus while read is low.
- R10: While write-ready is low, conversion-start stays high. Write-ready returns to 1 as the bus is released after the write, and conversions then resume.
- R11: The converter clock output follows the converter clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_clk_i | input | 1 | Free-running converter master clock |
| wreq_n_i | input | 1 | Register-write request, active low |
| wdata_i | input | 12 | Register-write data, held until write-ready returns high |
| result_o | output | 16 | Channel tag [15:12] and sample [11:0] |
| rd_ready_o | output | 1 | A valid result is present |
| wr_ready_o | output | 1 | Low while a register write is owed or in progress |
| adc_db | inout | 12 | Bidirectional converter data bus |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_wr_n | output | 1 | Converter write strobe, active low |
| adc_wb_n | output | 1 | Word/byte select, high for 12-bit words |
| adc_conv_clk | output | 1 | Forwarded converter clock |
| adc_convst_n | output | 1 | Conversion start, active low |
| adc_busy_i | input | 1 | Converter busy flag |

## Verification
The bench builds the block with STROBE_CYC=3 and GAP_CYC=2, so a wrong strobe length or a miscounted gap cannot match by chance the way it could at 1 or 2. The converter clock runs at a quarter of the system rate with two synchroniser stages. This makes the 13-edge conversion window long enough for a write request to land well inside a conversion, which exercises the hold-off path. A request placed just after a read lands in the gap, which exercises the immediate acknowledge.

// File: rtl/sar_pbus_pkg.sv
package sar_pbus_pkg;
   typedef enum logic [2:0] {
      ST_GAP       = 3'd0,
      ST_CONV_LO   = 3'd1,
      ST_CONV_WAIT = 3'd2,
      ST_READ      = 3'd3,
      ST_W_SETUP   = 3'd4,
      ST_W_STROBE  = 3'd5,
      ST_W_HOLD    = 3'd6
   } seq_state_t;
endpackage

// File: rtl/sar_pbus_sync.sv
module sar_pbus_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sar_pbus_sync: STAGES must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < W; b++) begin : g_bit
         logic [STAGES-1:0] pipe;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe <= RST_VAL;
               else        pipe <= d[b];
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe <= {STAGES{RST_VAL}};
               else        pipe <= {pipe[STAGES-2:0], d[b]};
         end
         assign q[b] = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sar_pbus_wr_arb.sv
module sar_pbus_wr_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic wreq_n,
   input  logic converting,
   input  logic wr_done,
   output logic wr_rdy,
   output logic wr_want
);
   logic wreq_q;
   logic pend;
   logic fall;

   assign fall    = wreq_q & ~wreq_n;
   assign wr_want = fall | pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wreq_q <= 1'b1;
         pend   <= 1'b0;
         wr_rdy <= 1'b1;
      end else begin
         wreq_q <= wreq_n;
         if (wr_done) begin
            wr_rdy <= 1'b1;
         end else if (wr_rdy && wr_want && !converting) begin
            wr_rdy <= 1'b0;
            pend   <= 1'b0;
         end else if (fall) begin
            pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sar_pbus_seq.sv
module sar_pbus_seq
   import sar_pbus_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int TAG_W      = 4,
   parameter int STROBE_CYC = 2,
   parameter int GAP_CYC    = 1,
   parameter int CONV_CLKS  = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    conv_s,
   input  logic                    busy_s,
   input  logic                    wr_rdy,
   input  logic                    wr_want,
   input  logic [DATA_W-1:0]       db_in,
   input  logic [DATA_W-1:0]       wdata_i,
   output seq_state_t              state,
   output logic                    converting,
   output logic                    wr_done,
   output logic [TAG_W+DATA_W-1:0] result,
   output logic                    rd_valid,
   output logic [DATA_W-1:0]       wdata_q
);
   localparam int MAXV = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
   localparam int CW   = $clog2(MAXV + 1);
   localparam int VW   = $clog2(CONV_CLKS + 1);

   logic [CW-1:0] cnt;
   logic [VW-1:0] conv_cnt;
   logic          conv_q;
   logic          conv_rise;

   assign conv_rise  = conv_s & ~conv_q;
   assign converting = (state == ST_CONV_LO) || (state == ST_CONV_WAIT);
   assign wr_done    = (state == ST_W_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q   <= 1'b0;
         conv_cnt <= '0;
      end else begin
         conv_q <= conv_s;
         if (!converting)
            conv_cnt <= '0;
         else if (conv_rise && conv_cnt != VW'(CONV_CLKS))
            conv_cnt <= conv_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_GAP;
         cnt      <= CW'(GAP_CYC - 1);
         result   <= '0;
         rd_valid <= 1'b0;
         wdata_q  <= '0;
      end else begin
         case (state)
            ST_GAP: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (!wr_rdy || wr_want) begin
                  state <= ST_W_SETUP;
               end else begin
                  state <= ST_CONV_LO;
                  cnt   <= CW'(STROBE_CYC - 1);
               end
            end
            ST_CONV_LO: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else           state <= ST_CONV_WAIT;
            end
            ST_CONV_WAIT: begin
               if (conv_cnt == VW'(CONV_CLKS) && !busy_s) begin
                  state <= ST_READ;
                  cnt   <= CW'(STROBE_CYC - 1);
               end
            end
            ST_READ: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  result   <= {{TAG_W{1'b0}}, db_in};
                  rd_valid <= 1'b1;
                  state    <= ST_GAP;
                  cnt      <= CW'(GAP_CYC - 1);
               end
            end
            ST_W_SETUP: begin
               wdata_q <= wdata_i;
               state   <= ST_W_STROBE;
               cnt     <= CW'(STROBE_CYC - 1);
            end
            ST_W_STROBE: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else           state <= ST_W_HOLD;
            end
            ST_W_HOLD: begin
               state <= ST_GAP;
               cnt   <= CW'(GAP_CYC - 1);
            end
            default: begin
               state <= ST_GAP;
               cnt   <= CW'(GAP_CYC - 1);
            end
         endcase
      end
   end
endmodule

// File: rtl/sar_pbus_ctrl.sv
module sar_pbus_ctrl
   import sar_pbus_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int TAG_W       = 4,
   parameter int STROBE_CYC  = 2,
   parameter int GAP_CYC     = 1,
   parameter int CONV_CLKS   = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    conv_clk_i,
   input  logic                    wreq_n_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [TAG_W+DATA_W-1:0] result_o,
   output logic                    rd_ready_o,
   output logic                    wr_ready_o,
   inout  wire  [DATA_W-1:0]       adc_db,
   output logic                    adc_cs_n,
   output logic                    adc_rd_n,
   output logic                    adc_wr_n,
   output logic                    adc_wb_n,
   output logic                    adc_conv_clk,
   output logic                    adc_convst_n,
   input  logic                    adc_busy_i
);
   generate
      if (STROBE_CYC < 1) begin : g_bad_strobe
         $error("sar_pbus_ctrl: STROBE_CYC must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("sar_pbus_ctrl: GAP_CYC must be at least 1");
      end
      if (CONV_CLKS < 1) begin : g_bad_conv
         $error("sar_pbus_ctrl: CONV_CLKS must be at least 1");
      end
      if (DATA_W < 1 || TAG_W < 0) begin : g_bad_width
         $error("sar_pbus_ctrl: bad data or tag width");
      end
   endgenerate

   seq_state_t        state;
   logic [1:0]        sync_q;
   logic              converting;
   logic              wr_done;
   logic              wr_rdy;
   logic              wr_want;
   logic              bus_oe;
   logic [DATA_W-1:0] wdata_q;

   sar_pbus_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({adc_busy_i, conv_clk_i}),
      .q     (sync_q)
   );

   sar_pbus_wr_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .wreq_n     (wreq_n_i),
      .converting (converting),
      .wr_done    (wr_done),
      .wr_rdy     (wr_rdy),
      .wr_want    (wr_want)
   );

   sar_pbus_seq #(
      .DATA_W     (DATA_W),
      .TAG_W      (TAG_W),
      .STROBE_CYC (STROBE_CYC),
      .GAP_CYC    (GAP_CYC),
      .CONV_CLKS  (CONV_CLKS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_s     (sync_q[0]),
      .busy_s     (sync_q[1]),
      .wr_rdy     (wr_rdy),
      .wr_want    (wr_want),
      .db_in      (adc_db),
      .wdata_i    (wdata_i),
      .state      (state),
      .converting (converting),
      .wr_done    (wr_done),
      .result     (result_o),
      .rd_valid   (rd_ready_o),
      .wdata_q    (wdata_q)
   );

   assign bus_oe       = (state == ST_W_SETUP) || (state == ST_W_STROBE) || (state == ST_W_HOLD);
   assign adc_db       = bus_oe ? wdata_q : {DATA_W{1'bz}};
   assign adc_convst_n = (state != ST_CONV_LO);
   assign adc_rd_n     = (state != ST_READ);
   assign adc_wr_n     = (state != ST_W_STROBE);
   assign adc_cs_n     = (state != ST_READ) && (state != ST_W_STROBE);
   assign adc_wb_n     = 1'b1;
   assign adc_conv_clk = conv_clk_i;
   assign wr_ready_o   = wr_rdy;
endmodule

// File: rtl/sar_pbus_ctrl_chk.sv
module sar_pbus_ctrl_chk #(
   parameter int RW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_ready,
   input logic          rd_ready,
   input logic          cs_n,
   input logic          rd_n,
   input logic          wr_n,
   input logic          convst_n,
   input logic          bus_oe,
   input logic [RW-1:0] result
);
   AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !cs_n); // R3
   AST_CONVST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !convst_n |-> (cs_n && rd_n && wr_n)); // R2
   AST_GAP_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(convst_n) |-> $past(rd_n)); // R5
   AST_RD_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |=> rd_ready); // R4
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && $past(rd_n)) |-> $stable(result)); // R3
   AST_NO_CONV_WRITE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ready |-> convst_n); // R10
   AST_BUS_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> rd_n); // R9
   AST_BUS_AROUND_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (bus_oe && $past(bus_oe))); // R9
   AST_WR_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !wr_ready); // R8
endmodule

bind sar_pbus_ctrl sar_pbus_ctrl_chk #(.RW(TAG_W + DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_ready (wr_ready_o),
   .rd_ready (rd_ready_o),
   .cs_n     (adc_cs_n),
   .rd_n     (adc_rd_n),
   .wr_n     (adc_wr_n),
   .convst_n (adc_convst_n),
   .bus_oe   (bus_oe),
   .result   (result_o)
);

// File: tb/sar_pbus_ctrl_bench.sv
`timescale 1ns/1ps
module sar_pbus_ctrl_bench;
   localparam int STROBE = 3;
   localparam int GAP    = 2;
   localparam int NCONV  = 13;

   logic        clk = 1'b0;
   logic        conv_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wreq_n = 1'b1;
   logic [11:0] wdata = '0;
   logic [15:0] result;
   logic        rd_ready, wr_ready;
   wire  [11:0] adc_db;
   logic        cs_n, rd_n, wr_n, wb_n, conv_clk_o, convst_n;
   logic        busy = 1'b0;
   logic [11:0] sample = '0;
   int          conv_idx = 0;
   logic [11:0] last_wr = '0;
   int          wr_count = 0;
   int          conv_edges = 0;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;
   always #40 conv_clk = ~conv_clk;

   sar_pbus_ctrl #(.STROBE_CYC(STROBE), .GAP_CYC(GAP), .CONV_CLKS(NCONV)) u_sar_pbus_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_clk_i   (conv_clk),
      .wreq_n_i     (wreq_n),
      .wdata_i      (wdata),
      .result_o     (result),
      .rd_ready_o   (rd_ready),
      .wr_ready_o   (wr_ready),
      .adc_db       (adc_db),
      .adc_cs_n     (cs_n),
      .adc_rd_n     (rd_n),
      .adc_wr_n     (wr_n),
      .adc_wb_n     (wb_n),
      .adc_conv_clk (conv_clk_o),
      .adc_convst_n (convst_n),
      .adc_busy_i   (busy)
   );

   // converter model
   assign adc_db = (!cs_n && !rd_n) ? sample : 12'bz;

   always @(posedge conv_clk) conv_edges++;

   always @(negedge convst_n) begin
      if (rst_n === 1'b1) begin
         #5 busy = 1'b1;
         repeat (NCONV) @(posedge conv_clk);
         sample = 12'h5A3 ^ 12'(conv_idx * 291);
         conv_idx++;
         busy = 1'b0;
      end
   end

   always @(posedge wr_n) begin
      if (rst_n === 1'b1) begin
         last_wr = adc_db;
         wr_count++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // strobe monitor
   int  cv_lo = 0, rd_lo = 0, wr_lo = 0, idle = 0, edges_at_start = 0;
   logic p_cv = 1'b1, p_rd = 1'b1, p_wr = 1'b1;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (p_cv && !convst_n) begin
            chk(idle >= GAP, "R5 idle clocks before conversion", idle, GAP);
            chk(wr_ready == 1'b1, "R10 conversion while write owed", wr_ready, 1);
            edges_at_start = conv_edges;
         end
         if (!p_cv && convst_n) chk(cv_lo == STROBE, "R2 convst low width", cv_lo, STROBE);
         if (p_rd && !rd_n) begin
            chk(busy == 1'b0, "R2 read while busy", busy, 0);
            chk(conv_edges - edges_at_start >= NCONV, "R2 converter edges before read",
                conv_edges - edges_at_start, NCONV);
            chk(!cs_n, "R3 chip select with read", cs_n, 0);
         end
         if (!p_rd && rd_n) begin
            chk(rd_lo == STROBE, "R3 read low width", rd_lo, STROBE);
            chk(result == {4'h0, sample}, "R3 result word", result, {4'h0, sample});
            chk(rd_ready == 1'b1, "R4 ready after capture", rd_ready, 1);
         end
         if (!wr_n) chk(!cs_n && wb_n, "R8 write strobe with cs and word mode", {cs_n, wb_n}, 1);
         if (!p_wr && wr_n) chk(wr_lo == STROBE, "R8 write low width", wr_lo, STROBE);
         cv_lo = convst_n ? 0 : cv_lo + 1;
         rd_lo = rd_n ? 0 : rd_lo + 1;
         wr_lo = wr_n ? 0 : wr_lo + 1;
         idle  = (rd_n && wr_n && cs_n && convst_n) ? idle + 1 : 0;
      end
      p_cv = convst_n;
      p_rd = rd_n;
      p_wr = wr_n;
   end

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({cs_n, rd_n, wr_n, convst_n} == 4'hF, "R1 strobes in reset", {cs_n, rd_n, wr_n, convst_n}, 4'hF);
      chk(wr_ready == 1'b1 && rd_ready == 1'b0, "R1 ready flags in reset", {wr_ready, rd_ready}, 2'b10);
      chk(result == 16'h0, "R1 result in reset", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({cs_n, rd_n, wr_n, convst_n} == 4'hF, "R1 strobes after release", {cs_n, rd_n, wr_n, convst_n}, 4'hF);
      chk(wr_ready == 1'b1 && rd_ready == 1'b0, "R1 flags after release", {wr_ready, rd_ready}, 2'b10);
      for (int i = 0; i < 6; i++) begin
         #13;
         chk(conv_clk_o == conv_clk, "R11 converter clock forwarded", conv_clk_o, conv_clk);
      end
   endtask

   task automatic t_stream();
      @(negedge rd_n);
      @(negedge clk);
      chk(rd_ready == 1'b0, "R4 ready before first capture", rd_ready, 0);
      repeat (4) @(posedge rd_n);
      @(negedge clk);
      chk(result[15:12] == 4'h0, "R3 channel tag zero", result[15:12], 0);
      chk(rd_ready == 1'b1, "R4 ready held", rd_ready, 1);
   endtask

   task automatic t_write_idle();
      int n0;
      n0 = wr_count;
      @(posedge rd_n);
      @(negedge clk);
      wreq_n = 1'b0;
      chk(wr_ready == 1'b1, "R6 ready before sample", wr_ready, 1);
      @(negedge clk);
      chk(wr_ready == 1'b0, "R6 ready one clock after request", wr_ready, 0);
      wdata = 12'h3C5;
      @(posedge wr_ready);
      @(negedge clk);
      wreq_n = 1'b1;
      chk(wr_count == n0 + 1, "R8 one write strobe", wr_count, n0 + 1);
      chk(last_wr == 12'h3C5, "R8 write data on bus", last_wr, 12'h3C5);
      chk(wr_n == 1'b1 && cs_n == 1'b1, "R10 strobes idle after write", {wr_n, cs_n}, 2'b11);
   endtask

   task automatic t_write_busy();
      int n0;
      n0 = wr_count;
      @(negedge convst_n);
      @(negedge clk);
      wreq_n = 1'b0;
      @(negedge clk);
      wdata = 12'h8E1;
      while (busy || !convst_n) begin
         chk(wr_ready == 1'b1, "R7 ready held during conversion", wr_ready, 1);
         @(negedge clk);
      end
      @(negedge wr_ready);
      @(posedge wr_ready);
      @(negedge clk);
      wreq_n = 1'b1;
      chk(wr_count == n0 + 1, "R7 deferred write done", wr_count, n0 + 1);
      chk(last_wr == 12'h8E1, "R8 deferred write data", last_wr, 12'h8E1);
   endtask

   task automatic t_resume();
      int c0;
      c0 = conv_idx;
      repeat (2) @(posedge rd_n);
      @(negedge clk);
      chk(conv_idx >= c0 + 2, "R10 conversions resume", conv_idx, c0 + 2);
      chk(result == {4'h0, sample}, "R9 read after write uncorrupted", result, {4'h0, sample});
   endtask

   initial begin
      t_reset();
      t_stream();
      t_write_idle();
      t_write_busy();
      t_resume();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule